// File: doc/BRIEF.md
# Dual-Buffer Ethernet Receive Frame Store

This block takes the byte stream coming out of a simple Ethernet receiver and stores each frame in one of two frame buffers, called ping and pong. The stream carries one byte per valid cycle and marks the first and last byte of a frame. The block fills the two buffers in strict turn. When a frame is fully stored it sets that buffer's done flag. If the buffer's interrupt enable is set, it also raises a one-cycle interrupt. Software reads the stored words over a 32-bit register bus and then clears the done flag, which hands the buffer back to the hardware.

A frame that arrives while its target buffer is still owned by software is dropped as a whole. Bytes past the data capacity of a buffer are discarded, and a sticky flag records the loss. A build-time parameter removes the pong buffer, and then every frame goes to ping. The window size is also a parameter. Each buffer window is 2^WIN_LOG2 bytes: all of its words hold data except the top word, which is the status register.

Top module: `eth_rx_pingpong`

## Requirements
- R1: After reset, every status register reads 0, irq is low and bus_rdata is 0.
- R2: The receive region starts at byte address 2^(WIN_LOG2+1), which is 0x1000 by default. The ping window comes first and the pong window sits 2^WIN_LOG2 bytes above it. The last word of each window is its status register (0x17FC and 0x1FFC by default), and every other word is data. A read returns its value on bus_rdata in the cycle after bus_re, and a read outside the region returns 0.
- R3: Frame bytes are packed into data words with the first byte in bits 31:24, starting at word 0 of the window. A final partial word has its unused low bytes set to zero.
- R4: Status bit 0 (done) is set in the cycle the last byte of a stored frame is taken. It stays set until a bus write to that status register has bit 0 at 0. Writing 1 to bit 0 leaves it unchanged.
- R5: With the pong buffer present, stored frames go to ping, pong, ping and so on. The turn moves on only when a frame is stored.
- R6: A frame whose first byte arrives while its target buffer's done bit is set is dropped. No data word, status bit or interrupt changes, and the turn does not move.
- R7: Bytes beyond 2^WIN_LOG2-4 per frame are discarded. Status bit 1 is then set when the frame completes and stays set until a status write has bit 1 at 0.
- R8: Status bit 3 is the interrupt enable and reads back as written. irq is high for exactly the cycle after the last byte of a stored frame when that buffer's enable is set, and stays low otherwise.
- R9: Writing 0x8 to a status register clears its done and overflow bits and sets its enable, so the buffer is free again.
- R10: With HAS_PONG=0, every stored frame goes to ping, a frame arriving while ping is done is dropped, the pong window reads 0 and writes to it are ignored.
- R11: Valid bytes outside a frame (before a start marker) are ignored. A start marker inside a frame abandons that frame and starts a new one into the same buffer.
- R12: Bus writes to data words have no effect on the stored contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Receive byte valid |
| rx_sof | input | 1 | First byte of a frame |
| rx_eof | input | 1 | Last byte of a frame |
| rx_data | input | 8 | Receive byte |
| bus_addr | input | WIN_LOG2+2 | Byte address of the register bus |
| bus_we | input | 1 | Bus write strobe |
| bus_wdata | input | 32 | Bus write data |
| bus_re | input | 1 | Bus read strobe |
| bus_rdata | output | 32 | Bus read data, valid the cycle after bus_re |
| irq | output | 1 | One-cycle frame-received interrupt |

## Verification
The bench builds two copies with WIN_LOG2=6, one with the pong buffer and one without, so each buffer holds only 60 bytes. This small size brings truncation and the overflow flag within reach of short random frames. Both copies share one stimulus stream. That puts the dropping of frames against a full buffer, the single-buffer fallback and the alternation pointer side by side, and a frame that one copy stores is dropped by the other. Directed cases cover frame lengths of one byte, exact word multiples, exactly full, one byte over, stray bytes without a start marker and an abandoned frame.

// File: rtl/rxpp_pkg.sv
package rxpp_pkg;

  localparam int STAT_DONE_BIT = 0;
  localparam int STAT_OVF_BIT  = 1;
  localparam int STAT_IE_BIT   = 3;

  typedef struct packed {
    logic ie;
    logic ovf;
    logic done;
  } rxpp_stat_t;

  typedef enum logic [1:0] {
    RD_ZERO = 2'd0,
    RD_RAM  = 2'd1,
    RD_STAT = 2'd2
  } rxpp_rd_kind_t;

  function automatic logic [31:0] stat_word(input rxpp_stat_t s);
    logic [31:0] w;
    w = '0;
    w[STAT_DONE_BIT] = s.done;
    w[STAT_OVF_BIT]  = s.ovf;
    w[STAT_IE_BIT]   = s.ie;
    return w;
  endfunction

endpackage

// File: rtl/rxpp_ram.sv
module rxpp_ram #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/rxpp_packer.sv
module rxpp_packer #(
  parameter int WIN_LOG2 = 11,
  parameter int NBUF     = 2,
  localparam int WW      = WIN_LOG2 - 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rx_valid,
  input  logic          rx_sof,
  input  logic          rx_eof,
  input  logic [7:0]    rx_data,
  input  logic          nxt_buf,
  input  logic          nxt_busy,
  output logic          mem_we,
  output logic          mem_buf,
  output logic [WW-1:0] mem_idx,
  output logic [31:0]   mem_wdata,
  output logic          fin,
  output logic          fin_buf,
  output logic          fin_ovf
);

  // data words per window: all but the top (status) word
  localparam int CAP = (1 << WW) - 1;

  logic          in_frame, keep_q, tgt_q, ovf_q;
  logic [WW-1:0] idx_q;
  logic [1:0]    lane_q;
  logic [31:0]   acc_q;

  logic          c_keep, c_live, c_act, c_tgt, c_ovf, c_full, c_flush;
  logic [WW-1:0] c_idx;
  logic [1:0]    c_lane;
  logic [31:0]   c_acc, merged;

  always_comb begin
    c_live  = rx_valid && (rx_sof || in_frame);
    c_keep  = rx_sof ? !nxt_busy : keep_q;
    c_act   = c_live && c_keep;
    c_tgt   = rx_sof ? ((NBUF > 1) ? nxt_buf : 1'b0) : tgt_q;
    c_idx   = rx_sof ? '0 : idx_q;
    c_lane  = rx_sof ? 2'd0 : lane_q;
    c_acc   = rx_sof ? '0 : acc_q;
    c_ovf   = rx_sof ? 1'b0 : ovf_q;
    c_full  = (c_idx == WW'(CAP));
    c_flush = (c_lane == 2'd3) || rx_eof;
    case (c_lane)
      2'd0:    merged = {rx_data, 24'h0};
      2'd1:    merged = {c_acc[31:24], rx_data, 16'h0};
      2'd2:    merged = {c_acc[31:16], rx_data, 8'h0};
      default: merged = {c_acc[31:8], rx_data};
    endcase
    mem_we    = c_act && !c_full && c_flush;
    mem_buf   = c_tgt;
    mem_idx   = c_idx;
    mem_wdata = merged;
    fin       = c_act && rx_eof;
    fin_buf   = c_tgt;
    fin_ovf   = c_ovf || c_full;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      in_frame <= 1'b0;
      keep_q   <= 1'b0;
      tgt_q    <= 1'b0;
      ovf_q    <= 1'b0;
      idx_q    <= '0;
      lane_q   <= 2'd0;
      acc_q    <= '0;
    end else if (c_live) begin
      in_frame <= !rx_eof;
      keep_q   <= c_keep;
      tgt_q    <= c_tgt;
      idx_q    <= c_idx;
      lane_q   <= c_lane;
      acc_q    <= c_acc;
      ovf_q    <= c_ovf;
      if (c_act) begin
        if (c_full) begin
          ovf_q <= 1'b1;
        end else if (c_flush) begin
          idx_q  <= c_idx + 1'b1;
          lane_q <= 2'd0;
          acc_q  <= '0;
        end else begin
          lane_q <= c_lane + 1'b1;
          acc_q  <= merged;
        end
      end
    end
  end

endmodule

// File: rtl/rxpp_status.sv
module rxpp_status
  import rxpp_pkg::*;
#(
  parameter int NBUF = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            fin,
  input  logic            fin_buf,
  input  logic            fin_ovf,
  input  logic            sw_we,
  input  logic            sw_buf,
  input  rxpp_stat_t      sw_val,
  output logic [NBUF-1:0] done,
  output logic [NBUF-1:0] ovf,
  output logic [NBUF-1:0] ie,
  output logic            nxt,
  output logic            irq
);

  logic [NBUF-1:0] set_vec, wr_vec;

  always_comb begin
    for (int b = 0; b < NBUF; b++) begin
      set_vec[b] = fin   && ((NBUF == 1) || (fin_buf == 1'(b)));
      wr_vec[b]  = sw_we && ((NBUF == 1) || (sw_buf  == 1'(b)));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done <= '0;
      ovf  <= '0;
      ie   <= '0;
      irq  <= 1'b0;
    end else begin
      for (int b = 0; b < NBUF; b++) begin
        if (wr_vec[b]) begin
          done[b] <= done[b] & sw_val.done;
          ovf[b]  <= ovf[b]  & sw_val.ovf;
          ie[b]   <= sw_val.ie;
        end
        if (set_vec[b]) begin
          done[b] <= 1'b1;
          if (fin_ovf) ovf[b] <= 1'b1;
        end
      end
      irq <= |(set_vec & ie);
    end
  end

  generate
    if (NBUF > 1) begin : g_turn
      always_ff @(posedge clk) begin
        if (rst)      nxt <= 1'b0;
        else if (fin) nxt <= !fin_buf;
      end
    end else begin : g_single
      assign nxt = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/eth_rx_pingpong.sv
module eth_rx_pingpong
  import rxpp_pkg::*;
#(
  parameter int WIN_LOG2 = 11,
  parameter bit HAS_PONG = 1'b1,
  localparam int AW      = WIN_LOG2 + 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rx_valid,
  input  logic          rx_sof,
  input  logic          rx_eof,
  input  logic [7:0]    rx_data,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_we,
  input  logic [31:0]   bus_wdata,
  input  logic          bus_re,
  output logic [31:0]   bus_rdata,
  output logic          irq
);

  localparam int NBUF = HAS_PONG ? 2 : 1;
  localparam int WW   = WIN_LOG2 - 2;
  localparam int RAW  = WW + ((NBUF > 1) ? 1 : 0);

  // bus decode
  logic          in_rx, b_sel, is_stat, buf_ok, sw_we;
  logic [WW-1:0] widx;
  rxpp_stat_t    sw_val;
  logic          bus_unused;

  assign in_rx      = bus_addr[AW-1];
  assign b_sel      = bus_addr[WIN_LOG2];
  assign widx       = bus_addr[WIN_LOG2-1:2];
  assign is_stat    = &widx;
  assign buf_ok     = HAS_PONG || !b_sel;
  assign sw_we      = bus_we && in_rx && is_stat && buf_ok;
  assign sw_val     = '{ie: bus_wdata[STAT_IE_BIT], ovf: bus_wdata[STAT_OVF_BIT],
                        done: bus_wdata[STAT_DONE_BIT]};
  assign bus_unused = ^{bus_wdata[31:4], bus_wdata[2], bus_addr[1:0]};

  // receive path
  logic          pk_we, pk_buf, fin, fin_buf, fin_ovf;
  logic [WW-1:0] pk_idx;
  logic [31:0]   pk_wdata;
  logic [NBUF-1:0] done_q, ovf_q, ie_q;
  logic          nxt_q, nxt_busy;

  always_comb begin
    nxt_busy = 1'b0;
    for (int b = 0; b < NBUF; b++)
      if ((NBUF == 1) || (nxt_q == 1'(b))) nxt_busy = done_q[b];
  end

  rxpp_packer #(.WIN_LOG2(WIN_LOG2), .NBUF(NBUF)) u_pack (
    .clk(clk), .rst(rst),
    .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_eof(rx_eof), .rx_data(rx_data),
    .nxt_buf(nxt_q), .nxt_busy(nxt_busy),
    .mem_we(pk_we), .mem_buf(pk_buf), .mem_idx(pk_idx), .mem_wdata(pk_wdata),
    .fin(fin), .fin_buf(fin_buf), .fin_ovf(fin_ovf)
  );

  rxpp_status #(.NBUF(NBUF)) u_stat (
    .clk(clk), .rst(rst),
    .fin(fin), .fin_buf(fin_buf), .fin_ovf(fin_ovf),
    .sw_we(sw_we), .sw_buf(b_sel), .sw_val(sw_val),
    .done(done_q), .ovf(ovf_q), .ie(ie_q), .nxt(nxt_q), .irq(irq)
  );

  // frame storage
  logic [RAW-1:0] ram_wa, ram_ra;
  logic [31:0]    ram_q;
  logic           buf_unused;

  generate
    if (NBUF > 1) begin : g_two
      assign ram_wa     = {pk_buf, pk_idx};
      assign ram_ra     = {b_sel, widx};
      assign buf_unused = 1'b0;
    end else begin : g_one
      assign ram_wa     = pk_idx;
      assign ram_ra     = widx;
      assign buf_unused = pk_buf;
    end
  endgenerate

  rxpp_ram #(.ADDR_W(RAW), .DATA_W(32)) u_ram (
    .clk(clk), .we(pk_we), .waddr(ram_wa), .wdata(pk_wdata),
    .re(bus_re), .raddr(ram_ra), .rdata(ram_q)
  );

  // read return
  rxpp_rd_kind_t rd_kind_q;
  logic [31:0]   stat_q, stat_now;

  always_comb begin
    stat_now = '0;
    for (int b = 0; b < NBUF; b++)
      if ((NBUF == 1) || (b_sel == 1'(b)))
        stat_now = stat_word('{ie: ie_q[b], ovf: ovf_q[b], done: done_q[b]});
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_kind_q <= RD_ZERO;
      stat_q    <= '0;
    end else if (bus_re) begin
      stat_q <= stat_now;
      if (!in_rx || !buf_ok) rd_kind_q <= RD_ZERO;
      else if (is_stat)      rd_kind_q <= RD_STAT;
      else                   rd_kind_q <= RD_RAM;
    end
  end

  always_comb begin
    case (rd_kind_q)
      RD_RAM:  bus_rdata = ram_q;
      RD_STAT: bus_rdata = stat_q;
      default: bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/eth_rx_pingpong_chk.sv
module eth_rx_pingpong_chk #(
  parameter int NB = 2
) (
  input logic          clk,
  input logic          rst,
  input logic          rx_valid,
  input logic          rx_eof,
  input logic          bus_we,
  input logic          irq,
  input logic [NB-1:0] done,
  input logic [NB-1:0] ie,
  input logic          nxt
);

  // R1: first cycle out of reset is quiet
  a_r1_reset_quiet: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!irq && (done == '0) && (ie == '0)));

  genvar b;
  generate
    for (b = 0; b < NB; b++) begin : g_buf
      // R4: done only rises on a frame's last byte
      a_r4_done_sets_on_eof: assert property (@(posedge clk) disable iff (rst)
        $rose(done[b]) |-> $past(rx_valid && rx_eof));
      // R4: done only falls through a bus write
      a_r4_done_clears_by_bus: assert property (@(posedge clk) disable iff (rst)
        $fell(done[b]) |-> $past(bus_we));
    end
  endgenerate

  // R5: the turn moves only when a frame completes
  a_r5_turn_moves_on_store: assert property (@(posedge clk) disable iff (rst)
    !$stable(nxt) |-> $past(rx_valid && rx_eof));

  // R8: an interrupt follows a completed frame into a done buffer
  a_r8_irq_after_frame: assert property (@(posedge clk) disable iff (rst)
    irq |-> ($past(rx_valid && rx_eof) && (done != '0)));

endmodule

bind eth_rx_pingpong eth_rx_pingpong_chk #(.NB(NBUF)) u_chk (
  .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_eof(rx_eof),
  .bus_we(bus_we), .irq(irq), .done(done_q), .ie(ie_q), .nxt(nxt_q)
);

// File: tb/sim_eth_rx_pingpong.sv
`timescale 1ns/100ps
module sim_eth_rx_pingpong;

  localparam int W    = 6;
  localparam int AW   = W + 2;
  localparam int BASE = 1 << (W + 1);
  localparam int WIN  = 1 << W;
  localparam int NWD  = (WIN / 4) - 1;
  localparam int CAPB = NWD * 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0;
  logic [7:0] rx_data = '0;
  logic [AW-1:0] bus_addr = '0;
  logic bus_we = 1'b0, bus_re = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] rdata0, rdata1;
  logic irq0, irq1;

  always #2.5 clk = ~clk;

  eth_rx_pingpong #(.WIN_LOG2(W), .HAS_PONG(1'b1)) u0 (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_eof(rx_eof),
    .rx_data(rx_data), .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .bus_re(bus_re), .bus_rdata(rdata0), .irq(irq0));

  eth_rx_pingpong #(.WIN_LOG2(W), .HAS_PONG(1'b0)) u1 (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_eof(rx_eof),
    .rx_data(rx_data), .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .bus_re(bus_re), .bus_rdata(rdata1), .irq(irq1));

  int n_chk = 0, n_fail = 0;
  bit done_flag = 0;

  // reference model, index [dut][buffer]
  logic [31:0] m_mem [2][2][NWD];
  bit          m_val [2][2][NWD];
  bit m_done [2][2];
  bit m_ovf  [2][2];
  bit m_ie   [2][2];
  bit m_nxt  [2];
  bit exp_irq [2];
  logic [7:0] fr [128];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_stat(input int d, input int b);
    if (d == 1 && b == 1) return 32'h0;
    return {28'h0, m_ie[d][b], 1'b0, m_ovf[d][b], m_done[d][b]};
  endfunction

  task automatic model_frame(input int len);
    for (int d = 0; d < 2; d++) begin
      int t = m_nxt[d];
      exp_irq[d] = 1'b0;
      if (!m_done[d][t]) begin
        int n = (len > CAPB) ? CAPB : len;
        for (int w = 0; w < (n + 3) / 4; w++) begin
          m_mem[d][t][w] = '0;
          m_val[d][t][w] = 1'b1;
        end
        for (int i = 0; i < n; i++)
          m_mem[d][t][i/4] = m_mem[d][t][i/4] | (32'(fr[i]) << (8 * (3 - (i % 4))));
        if (len > CAPB) m_ovf[d][t] = 1'b1;
        m_done[d][t] = 1'b1;
        exp_irq[d] = m_ie[d][t];
        if (d == 0) m_nxt[d] = !m_nxt[d];
      end
    end
  endtask

  // drive len bytes; with_sof=0 drives a stray stream that must be ignored
  task automatic send(input int len, input bit with_sof, input bit with_eof);
    if (with_sof && with_eof) model_frame(len);
    else begin exp_irq[0] = 1'b0; exp_irq[1] = 1'b0; end
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      rx_valid = 1'b1;
      rx_sof   = with_sof && (i == 0);
      rx_eof   = with_eof && (i == len - 1);
      rx_data  = fr[i];
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0;
    chk(irq0 == exp_irq[0], "R8 irq u0", 32'(irq0), 32'(exp_irq[0]));
    chk(irq1 == exp_irq[1], "R8 irq u1", 32'(irq1), 32'(exp_irq[1]));
  endtask

  task automatic rd(input int addr, output logic [31:0] r0, output logic [31:0] r1);
    @(negedge clk);
    bus_re = 1'b1; bus_addr = AW'(addr);
    @(negedge clk);
    bus_re = 1'b0;
    r0 = rdata0; r1 = rdata1;
  endtask

  task automatic wr(input int addr, input logic [31:0] data);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = AW'(addr); bus_wdata = data;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic wr_stat(input int b, input logic [31:0] data);
    wr(BASE + b * WIN + WIN - 4, data);
    for (int d = 0; d < 2; d++) begin
      if (!(d == 1 && b == 1)) begin
        m_done[d][b] = m_done[d][b] & data[0];
        m_ovf[d][b]  = m_ovf[d][b]  & data[1];
        m_ie[d][b]   = data[3];
      end
    end
  endtask

  task automatic check_all(input string tag);
    logic [31:0] r0, r1;
    for (int b = 0; b < 2; b++) begin
      rd(BASE + b * WIN + WIN - 4, r0, r1);
      chk(r0 == exp_stat(0, b), {tag, " status u0"}, r0, exp_stat(0, b));
      chk(r1 == exp_stat(1, b), {tag, " status u1 (R10)"}, r1, exp_stat(1, b));
      for (int w = 0; w < NWD; w++) begin
        rd(BASE + b * WIN + 4 * w, r0, r1);
        if (m_val[0][b][w])
          chk(r0 == m_mem[0][b][w], {tag, " data u0 R3"}, r0, m_mem[0][b][w]);
        if (b == 1)
          chk(r1 == 32'h0, {tag, " pong u1 R10"}, r1, 32'h0);
        else if (m_val[1][b][w])
          chk(r1 == m_mem[1][b][w], {tag, " data u1 R3"}, r1, m_mem[1][b][w]);
      end
    end
  endtask

  task automatic fill(input int len);
    for (int i = 0; i < len; i++) fr[i] = 8'($urandom);
  endtask

  task automatic summary();
    if (!done_flag) begin
      done_flag = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish (all requirements)");
    summary();
  end

  initial begin
    logic [31:0] r0, r1;
    void'($urandom(32'd5907));
    for (int d = 0; d < 2; d++) begin
      m_nxt[d] = 0;
      for (int b = 0; b < 2; b++) begin
        m_done[d][b] = 0; m_ovf[d][b] = 0; m_ie[d][b] = 0;
        for (int w = 0; w < NWD; w++) begin m_val[d][b][w] = 0; m_mem[d][b][w] = '0; end
      end
    end
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk(rdata0 == 32'h0 && rdata1 == 32'h0, "R1 rdata after reset", rdata0 | rdata1, 32'h0);
    chk(irq0 == 1'b0 && irq1 == 1'b0, "R1 irq after reset", 32'(irq0 | irq1), 32'h0);
    rd(BASE + WIN - 4, r0, r1);
    chk(r0 == 32'h0 && r1 == 32'h0, "R1 ping status after reset", r0 | r1, 32'h0);
    rd(BASE + 2 * WIN - 4, r0, r1);
    chk(r0 == 32'h0, "R1 pong status after reset", r0, 32'h0);
    // R2: read outside the receive region
    rd(16, r0, r1);
    chk(r0 == 32'h0 && r1 == 32'h0, "R2 outside region reads zero", r0 | r1, 32'h0);

    // R8/R9: enable interrupt on ping
    wr_stat(0, 32'h8);
    // R3/R4: 5-byte frame into ping, partial word padded
    fill(5); send(5, 1, 1); check_all("R4 first frame");
    // R5/R6/R10: u0 goes to pong, u1 drops (ping done)
    fill(4); send(4, 1, 1); check_all("R5 second frame");
    // R6: both full in u0, frame dropped
    fill(61); send(61, 1, 1); check_all("R6 dropped frame");
    // R9: flush ping, then oversize frame sets overflow (R7)
    wr_stat(0, 32'h8);
    rd(BASE + WIN - 4, r0, r1);
    chk(r0 == 32'h8, "R9 flush reads 0x8", r0, 32'h8);
    fill(61); send(61, 1, 1); check_all("R7 overflow frame");
    // R7/R4: keep done, clear overflow
    wr_stat(0, 32'h9); check_all("R7 overflow cleared");
    // release everything
    wr_stat(0, 32'h0); wr_stat(1, 32'h0);
    // R11: stray bytes without a start marker
    fill(6); send(6, 0, 1); check_all("R11 stray bytes");
    // R11: abandoned frame then restart
    fill(3); send(3, 1, 0);
    fill(9); send(9, 1, 1); check_all("R11 restart");
    // R12: writes to data words are ignored
    wr(BASE, 32'hDEADBEEF); wr(BASE + WIN + 4, 32'h12345678);
    check_all("R12 data write ignored");
    wr_stat(0, 32'h8); wr_stat(1, 32'h8);
    // exactly full, no overflow (R7 boundary), single byte frame (R3)
    fill(CAPB); send(CAPB, 1, 1); check_all("R7 exactly full");
    fill(1); send(1, 1, 1); check_all("R3 single byte");

    // constrained random phase
    for (int it = 0; it < 40; it++) begin
      int len = 1 + ($urandom % 70);
      fill(len);
      send(len, 1, 1);
      check_all("R5 random frame");
      for (int b = 0; b < 2; b++) begin
        if ($urandom % 2) begin
          logic [31:0] v;
          v = {28'h0, 1'($urandom), 1'b0, 1'($urandom), 1'($urandom % 4 == 0)};
          wr_stat(b, v);
        end
      end
    end
    summary();
  end

endmodule